// File: doc/BRIEF.md
# SPI Frame Chip-Select Generator

This block produces the chip-select line for an SPI master whose serial clock is made elsewhere. It watches that serial clock and counts the edges that sample data. When the count reaches a programmed frame length, it drives chip select to its inactive level for a short interval, so the slave latches the frame, and then returns it to the active level. The next frame therefore starts without any command per frame.

A frame can be much longer than one word. For example, seven chained 16-bit devices take a 112-bit frame, and all of their registers latch together. The release comes while the serial clock still holds the level of the last sampled bit. Slaves that latch on chip select during that final clock phase need this timing.

A single configuration strobe loads the frame length, the SPI mode and the active level together. The same strobe clears the bit counter and forces chip select to the chosen active level, which lets software hold the line high or low on demand.

Top module: `spi_frame_cs_gen`

## Requirements
- R1: After reset, the frame length is 0 and the mode is 0. The line is active-low, so `cs_out` is 0 and stays 0 while serial clock edges arrive.
- R2: SPI modes 0 and 3 count rising `sclk_in` edges. Modes 1 and 2 count falling edges. The mode code is the 2-bit value on `spi_mode`, and one counted edge is one bit.
- R3: The counted edge that brings the bit count up to the frame length wraps the counter to zero and releases chip select. If that `sclk_in` change is first seen at system clock edge k, `cs_out` is at its inactive level from edge k+2.
- R4: The release lasts exactly two system clock cycles. Chip select then returns to active, and the next frame is counted with no further command.
- R5: When `cs_act_high` is loaded as 1, the active level is high and the inactive level is low. When it is loaded as 0, the polarity is the reverse.
- R6: A cycle with `cfg_wr` high loads the frame length, the mode and the active level, and clears the bit counter. From the next cycle `cs_out` is at the new active level, which cancels any release in progress.
- R7: A frame length of 0 never releases chip select.
- R8: A frame length of 1 releases once per counted edge. Frames of many bits, such as 112, release only after the full count.
- R9: Changes on `frame_len`, `spi_mode` or `cs_act_high` while `cfg_wr` is low have no effect on counting or on the output.
- R10: When each `sclk_in` level lasts at least four system clock cycles, the release begins while `sclk_in` still holds the level of the last counted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Serial clock from the SPI master, asynchronous |
| frame_len | input | 32 | Frame length in bits, loaded on `cfg_wr` |
| spi_mode | input | 2 | SPI mode 0..3, loaded on `cfg_wr` |
| cs_act_high | input | 1 | 1 for an active-high line, 0 for active-low, loaded on `cfg_wr` |
| cfg_wr | input | 1 | Configuration load strobe; clears the counter and forces the active level |
| cs_out | output | 1 | Chip select |

## Verification
The checks on release width and counting assume that `sclk_in` edges are spaced far enough apart that no second frame end falls inside a two-cycle release. That means no sharper ratio than a one-bit frame with each serial clock level held at least two system cycles. The stimulus holds every serial clock level for four system cycles. Before each configuration strobe, the stimulus parks `sclk_in` at the idle level of the new mode and lets it settle through the synchronizer, so that no stray edge crosses the strobe.

// File: rtl/spi_fcs_pkg.sv
package spi_fcs_pkg;

  typedef enum logic [1:0] {
    SPI_M0 = 2'd0,
    SPI_M1 = 2'd1,
    SPI_M2 = 2'd2,
    SPI_M3 = 2'd3
  } spi_mode_e;

  // modes 0 and 3 sample on the rising edge of the serial clock
  function automatic logic counts_rising(spi_mode_e m);
    return (m == SPI_M0) || (m == SPI_M3);
  endfunction

  // line level for a given polarity and release state
  function automatic logic cs_level(logic act_high, logic released);
    return released ? ~act_high : act_high;
  endfunction

endpackage

// File: rtl/fcs_sclk_edge.sv
module fcs_sclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic rise,
  output logic fall
);
  localparam int WARM_MAX = STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic [WARM_W-1:0] warm;
  logic              synced;
  logic              armed;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= sclk_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], sclk_in};
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];
  assign armed  = (warm == WARM_W'(WARM_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      warm <= '0;
    end else begin
      prev <= synced;
      if (!armed) warm <= warm + WARM_W'(1);
    end
  end

  // no edge is reported until the chain holds real samples
  assign rise = armed &  synced & ~prev;
  assign fall = armed & ~synced &  prev;

endmodule

// File: rtl/fcs_frame_count.sv
module fcs_frame_count #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic [LEN_W-1:0] cnt,
  output logic             wrap
);
  function automatic logic last_bit(logic [LEN_W-1:0] c, logic [LEN_W-1:0] l);
    return (l != '0) && (c == l - LEN_W'(1));
  endfunction

  function automatic logic [LEN_W-1:0] advance(logic [LEN_W-1:0] c, logic [LEN_W-1:0] l);
    return last_bit(c, l) ? '0 : c + LEN_W'(1);
  endfunction

  assign wrap = step && last_bit(cnt, len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (step && len != '0)    cnt <= advance(cnt, len);
  end

endmodule

// File: rtl/fcs_release_pulse.sv
module fcs_release_pulse #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (cancel)      left <= '0;
    else if (start)       left <= TW'(CYCLES);
    else if (left != '0)  left <= left - TW'(1);
  end

  assign active = (left != '0);

endmodule

// File: rtl/spi_frame_cs_gen.sv
module spi_frame_cs_gen
  import spi_fcs_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RELEASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [1:0]       spi_mode,
  input  logic             cs_act_high,
  input  logic             cfg_wr,
  output logic             cs_out
);
  logic [LEN_W-1:0] len_q;
  spi_mode_e        mode_q;
  logic             act_q;

  logic             rise, fall;
  logic             edge_evt;
  logic             eof_evt;
  logic [LEN_W-1:0] cnt;
  logic             pulse_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= SPI_M0;
      act_q  <= 1'b0;
    end else if (cfg_wr) begin
      len_q  <= frame_len;
      mode_q <= spi_mode_e'(spi_mode);
      act_q  <= cs_act_high;
    end
  end

  fcs_sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .rise    (rise),
    .fall    (fall)
  );

  assign edge_evt = counts_rising(mode_q) ? rise : fall;

  fcs_frame_count #(.LEN_W(LEN_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_wr),
    .len   (len_q),
    .step  (edge_evt),
    .cnt   (cnt),
    .wrap  (eof_evt)
  );

  fcs_release_pulse #(.CYCLES(RELEASE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eof_evt),
    .cancel (cfg_wr),
    .active (pulse_active)
  );

  assign cs_out = cs_level(act_q, pulse_active);

endmodule

// File: rtl/spi_fcs_chk.sv
module spi_fcs_chk #(
  parameter int LEN_W       = 32,
  parameter int RELEASE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cs_act_high,
  input logic             cs_out,
  input logic             act_q,
  input logic [LEN_W-1:0] len_q,
  input logic [1:0]       mode_q,
  input logic [LEN_W-1:0] cnt,
  input logic             edge_evt,
  input logic             eof_evt
);
  logic [7:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          off_run <= '0;
    else if (cfg_wr || cs_out == act_q)  off_run <= '0;
    else if (off_run != 8'hFF)           off_run <= off_run + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r4_release_bounded: assert (off_run <= 8'(RELEASE_CYC))
        else $error("release longer than allowed");
    end
  end

  a_r6_force_level: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cs_out == $past(cs_act_high));

  a_r7_zero_len_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0) |-> !eof_evt);

  a_r3_release_start: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_evt && !cfg_wr) |=> cs_out == ~act_q);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && !eof_evt && !cfg_wr && len_q != '0) |=> cnt == $past(cnt) + LEN_W'(1));

  a_r2_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && !cfg_wr) |=> $stable(cnt));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(len_q) && $stable(mode_q) && $stable(act_q)));

endmodule

bind spi_frame_cs_gen spi_fcs_chk #(.LEN_W(LEN_W), .RELEASE_CYC(RELEASE_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cs_act_high (cs_act_high),
  .cs_out      (cs_out),
  .act_q       (act_q),
  .len_q       (len_q),
  .mode_q      (mode_q),
  .cnt         (cnt),
  .edge_evt    (edge_evt),
  .eof_evt     (eof_evt)
);

// File: tb/sim_spi_frame_cs_gen.sv
module sim_spi_frame_cs_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic [31:0] frame_len = '0;
  logic [1:0]  spi_mode = '0;
  logic        cs_act_high = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cs_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_cs_gen u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .frame_len(frame_len),
    .spi_mode(spi_mode), .cs_act_high(cs_act_high), .cfg_wr(cfg_wr), .cs_out(cs_out)
  );

  // vector: mode, active-high, frame length, bits sent, expected releases
  localparam int NV = 7;
  localparam logic [58:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'd8,   16'd24,  8'd3},
    {2'd1, 1'b1, 32'd5,   16'd17,  8'd3},
    {2'd2, 1'b0, 32'd16,  16'd32,  8'd2},
    {2'd3, 1'b1, 32'd3,   16'd10,  8'd3},
    {2'd0, 1'b0, 32'd1,   16'd5,   8'd5},
    {2'd2, 1'b1, 32'd0,   16'd12,  8'd0},
    {2'd3, 1'b0, 32'd112, 16'd224, 8'd2}
  };

  // monitor state
  logic mon_en = 1'b0;
  logic exp_act = 1'b0;
  logic exp_lvl = 1'b1;
  logic idle_lvl = 1'b0;
  int   pulses = 0, run = 0, wid_bad = 0, lvl_bad = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (cs_out !== exp_act) begin
        if (run == 0) begin
          pulses = pulses + 1;
          if (sclk_in !== exp_lvl) lvl_bad = lvl_bad + 1;
        end
        run = run + 1;
      end else begin
        if (run != 0 && run != 2) wid_bad = wid_bad + 1;
        run = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic ah, input logic [31:0] len);
    mon_en = 1'b0;
    repeat (2) @(negedge clk);
    #1 sclk_in = m[1];
    idle_lvl = m[1];
    repeat (6) @(negedge clk);
    #1;
    spi_mode = m; cs_act_high = ah; frame_len = len; cfg_wr = 1'b1;
    @(negedge clk);
    #1 cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    exp_act = ah;
    exp_lvl = (m == 2'd0 || m == 2'd3);
    pulses = 0; run = 0; wid_bad = 0; lvl_bad = 0;
    mon_en = 1'b1;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (HALF_CYC) @(negedge clk);
      #1 sclk_in = ~idle_lvl;
      repeat (HALF_CYC) @(negedge clk);
      #1 sclk_in = idle_lvl;
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state, active-low, length 0
    check(cs_out === 1'b0, "R1", "cs after reset", cs_out, 0);
    exp_act = 1'b0; exp_lvl = 1'b1; idle_lvl = 1'b0;
    repeat (6) @(negedge clk);
    mon_en = 1'b1;
    send_bits(6);
    check(pulses == 0, "R1", "releases with reset config", pulses, 0);

    // table walk: R2 R3 R4 R5 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      configure(VEC[v][58:57], VEC[v][56], VEC[v][55:24]);
      check(cs_out === VEC[v][56], "R5", "active level after load", cs_out, VEC[v][56]);
      send_bits(int'(VEC[v][23:8]));
      check(pulses == int'(VEC[v][7:0]), "R2", "release count", pulses, VEC[v][7:0]);
      check(wid_bad == 0, "R4", "release width not two", wid_bad, 0);
      check(lvl_bad == 0, "R10", "sclk level at release", lvl_bad, 0);
    end

    // R3: exact latency of the release, mode 0, active-low, length 1
    configure(2'd0, 1'b0, 32'd1);
    mon_en = 1'b0;
    @(negedge clk);
    #1 sclk_in = 1'b1;
    begin
      logic [4:0] seen;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        seen[i] = cs_out;
      end
      check(seen === 5'b01100, "R3", "release timing pattern", seen, 5'b01100);
    end
    repeat (4) @(negedge clk);
    #1 sclk_in = 1'b0;
    repeat (6) @(negedge clk);

    // R6: forcing the line with a load strobe
    @(negedge clk);
    #1 cs_act_high = 1'b1; cfg_wr = 1'b1;
    @(negedge clk);
    check(cs_out === 1'b1, "R6", "forced high next cycle", cs_out, 1);
    #1 cs_act_high = 1'b0;
    @(negedge clk);
    check(cs_out === 1'b0, "R6", "forced low next cycle", cs_out, 0);
    #1 cfg_wr = 1'b0;

    // R6: load strobe clears a partly counted frame
    configure(2'd0, 1'b0, 32'd4);
    send_bits(2);
    configure(2'd0, 1'b0, 32'd4);
    send_bits(2);
    check(pulses == 0, "R6", "count cleared by load", pulses, 0);
    send_bits(2);
    check(pulses == 1, "R6", "frame after clear", pulses, 1);

    // R9: inputs ignored without the strobe
    configure(2'd0, 1'b0, 32'd4);
    #1 frame_len = 32'd2; spi_mode = 2'd1; cs_act_high = 1'b1;
    send_bits(4);
    check(pulses == 1, "R9", "releases with stale inputs", pulses, 1);
    check(lvl_bad == 0, "R9", "mode unchanged (rising edge)", lvl_bad, 0);
    check(cs_out === 1'b0, "R9", "level unchanged", cs_out, 0);

    // R8: one-bit frames at the boundary
    configure(2'd1, 1'b1, 32'd1);
    send_bits(3);
    check(pulses == 3, "R8", "one release per bit", pulses, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule